// File: doc/BRIEF.md
# Windowed Peak Detector Status Router

This block watches two streams of signed digitized samples, one per clock, and reports over each gain update period whether the signal was loud or quiet. Each of the two peak paths counts the samples whose magnitude lies strictly above a high threshold and those above a low threshold. At the close of the period each count is compared with its own programmed limit. A high count that reaches its limit marks an overload. A low count that reaches its limit shows that no underload occurred. A power path squares the first stream's samples, sums them over the same period, and compares the mean against an inner low and an inner high level.

The period length is a programmable number of sample clocks. The flags are captured on the clock that takes the final sample of a period, and they hold for the whole of the next period. A mode input chooses which four flags form the exported status word. That word is split into two 2-bit pairs. Each pair can be placed on any adjacent pin pair of a 16-pin port, or left off the port altogether. A status interface of this kind suits gain control firmware that polls a handful of general-purpose pins.

Top module: `sigdet_status_router`

## Requirements
- R1: While `rst` is high and on the first clock after it, `status` is 0 and `pins` is 0.
- R2: A period is `period_len` sample clocks long, counted from the first clock after reset. Every period starts with fresh counts. The flags change only on the clock that takes a period's last sample, and they keep those values for the whole following period.
- R3: A sample counts against a threshold only when its absolute value is strictly greater than the threshold. This holds for either sign, and the most negative code -2048 has a magnitude of 2048.
- R4: On each peak path, the high flag is set when the high count is at least the high limit, and the low flag is set when the low count is at least the low limit.
- R5: The exceedance counters stop at 255 and do not wrap, so a period with more than 255 hits still meets a limit of 255.
- R6: Let N be the number of samples in the period. The power inner-low flag is set when the sum of `samp_a` squared over the period is strictly greater than `pwr_lo_thr` × N. The inner-high flag follows the same rule with `pwr_hi_thr`.
- R7: When `mode` = 0 (peak mode), `status` bits 0..3 are: path A low flag, path B low flag, path A high flag, path B high flag.
- R8: When `mode` = 1 (peak and power mode), `status` bits 0..3 are: power inner-low flag, power inner-high flag, path B low flag, path B high flag.
- R9: A selector code k in 1..8 places a pair on `pins[2k-1:2k-2]`. `sel_pair0` carries `status[1:0]` and `sel_pair1` carries `status[3:2]`, with the lower status bit on the lower pin.
- R10: Selector codes 0 and 9..15 leave a pair unassigned. Any pin not driven by a pair reads 0.
- R11: When both selectors name the same pin pair, that pair carries `status[1:0]`.
- R12: A change of `mode` or of a selector reaches `status` and `pins` combinationally, from the held flags, without waiting for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = peak status word, 1 = peak and power status word |
| period_len | input | 16 | Gain update period in sample clocks (at least 1) |
| samp_a | input | 12 | Path A sample, signed; also feeds the power path |
| samp_b | input | 12 | Path B sample, signed |
| a_hi_thr | input | 12 | Path A high magnitude threshold |
| a_lo_thr | input | 12 | Path A low magnitude threshold |
| a_hi_lim | input | 8 | Path A high count limit |
| a_lo_lim | input | 8 | Path A low count limit |
| b_hi_thr | input | 12 | Path B high magnitude threshold |
| b_lo_thr | input | 12 | Path B low magnitude threshold |
| b_hi_lim | input | 8 | Path B high count limit |
| b_lo_lim | input | 8 | Path B low count limit |
| pwr_lo_thr | input | 24 | Power inner-low mean level |
| pwr_hi_thr | input | 24 | Power inner-high mean level |
| sel_pair0 | input | 4 | Pin pair code for status[1:0] |
| sel_pair1 | input | 4 | Pin pair code for status[3:2] |
| status | output | 4 | Mode-selected status word |
| pins | output | 16 | Routed status pin port |

## Verification
The bench aims at the comparison edges. It feeds samples equal to a threshold, the same magnitude with both signs, -2048, and counts sitting exactly on a limit. A design using >= against the threshold, or > against the limit, would flip flags that the bench predicts. A 300-sample period with a limit of 255 catches a counter that wraps, and a power sum equal to the threshold times N catches a non-strict mean comparison. A one-sample period, plus a check of `status` on every clock of a period, exposes a design whose flags move early or late. Colliding and out-of-range selector codes expose a router that favours the wrong pair or drives a pin for codes 9..15.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

    localparam int PIN_PAIRS  = 8;
    localparam int PAIR_SEL_W = 4;
    localparam int PIN_W      = 2 * PIN_PAIRS;

    typedef enum logic {
        MODE_PEAK     = 1'b0,
        MODE_PEAK_PWR = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic pwr_hi;
        logic pwr_lo;
        logic b_hi;
        logic b_lo;
        logic a_hi;
        logic a_lo;
    } det_flags_t;

    // Assemble the exported 4-bit word for the chosen mode.
    function automatic logic [3:0] pick_status(det_mode_e m, det_flags_t f);
        logic [3:0] w;
        case (m)
            MODE_PEAK: w = {f.b_hi, f.a_hi, f.b_lo, f.a_lo};
            default:   w = {f.b_hi, f.b_lo, f.pwr_hi, f.pwr_lo};
        endcase
        return w;
    endfunction

    // True when a selector code names a real pin pair.
    function automatic logic pair_code_live(logic [PAIR_SEL_W-1:0] code);
        return (code != '0) && (code <= PAIR_SEL_W'(PIN_PAIRS));
    endfunction

endpackage

// File: rtl/sigdet_period_timer.sv
module sigdet_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_len,
    output logic [PER_W-1:0] pos,
    output logic             last
);
    logic [PER_W:0] pos_inc;

    assign pos_inc = {1'b0, pos} + {{PER_W{1'b0}}, 1'b1};
    // A length of 0 behaves as 1: every sample closes a period.
    assign last    = (pos_inc >= {1'b0, period_len});

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (last) begin
            pos <= '0;
        end else begin
            pos <= pos_inc[PER_W-1:0];
        end
    end
endmodule

// File: rtl/sigdet_peak_counter.sv
module sigdet_peak_counter #(
    parameter int SMP_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] samp,
    input  logic [SMP_W-1:0] thr_hi,
    input  logic [SMP_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic             last,
    output logic             flag_hi,
    output logic             flag_lo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [SMP_W-1:0]      mag;
    logic [1:0][SMP_W-1:0] thr;
    logic [1:0][CNT_W-1:0] lim;
    logic [1:0]            flag;

    // Two's complement negation in SMP_W bits yields the unsigned magnitude,
    // including the most negative code.
    assign mag = samp[SMP_W-1] ? ((~samp) + {{(SMP_W-1){1'b0}}, 1'b1}) : samp;
    assign thr = {thr_hi, thr_lo};
    assign lim = {lim_hi, lim_lo};

    for (genvar g = 0; g < 2; g++) begin : g_level
        logic             hit;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_nx;
        logic             flag_q;

        assign hit    = (mag > thr[g]);
        assign cnt_nx = (hit && (cnt_q != CNT_MAX)) ? cnt_q + CNT_ONE : cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else if (last) begin
                cnt_q  <= '0;
                flag_q <= (cnt_nx >= lim[g]);
            end else begin
                cnt_q  <= cnt_nx;
            end
        end

        assign flag[g] = flag_q;
    end

    assign flag_hi = flag[1];
    assign flag_lo = flag[0];
endmodule

// File: rtl/sigdet_power_meter.sv
module sigdet_power_meter #(
    parameter int SMP_W = 12,
    parameter int PER_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] samp,
    input  logic [2*SMP_W-1:0]      thr_lo,
    input  logic [2*SMP_W-1:0]      thr_hi,
    input  logic [PER_W-1:0]        pos,
    input  logic                    last,
    output logic                    flag_lo,
    output logic                    flag_hi
);
    localparam int SQ_W  = 2 * SMP_W;
    localparam int ACC_W = SQ_W + PER_W;

    logic signed [SQ_W-1:0]   sq_s;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W-1:0]         total;
    logic [PER_W:0]           n_smp;
    logic [1:0][SQ_W-1:0]     thr;
    logic [1:0]               flag;

    assign sq_s  = SQ_W'(samp) * SQ_W'(samp);
    assign total = acc_q + ACC_W'($unsigned(sq_s));
    assign n_smp = {1'b0, pos} + {{PER_W{1'b0}}, 1'b1};
    assign thr   = {thr_hi, thr_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (last) begin
            acc_q <= '0;
        end else begin
            acc_q <= total;
        end
    end

    // Mean > level is evaluated as sum > level * N, avoiding a divider.
    for (genvar g = 0; g < 2; g++) begin : g_level
        logic [ACC_W:0] bound;
        logic           flag_q;

        assign bound = (ACC_W + 1)'(thr[g]) * (ACC_W + 1)'(n_smp);

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (last) begin
                flag_q <= ({1'b0, total} > bound);
            end
        end

        assign flag[g] = flag_q;
    end

    assign flag_hi = flag[1];
    assign flag_lo = flag[0];
endmodule

// File: rtl/sigdet_pin_router.sv
module sigdet_pin_router #(
    parameter int PAIRS = 8,
    parameter int SEL_W = 4
) (
    input  logic [3:0]         status,
    input  logic [SEL_W-1:0]   sel0,
    input  logic [SEL_W-1:0]   sel1,
    output logic [2*PAIRS-1:0] pins
);
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        // Pair 0 wins when both selectors name this slot.
        assign pins[2*k +: 2] = (sel0 == SEL_W'(k + 1)) ? status[1:0] :
                                (sel1 == SEL_W'(k + 1)) ? status[3:2] : 2'b00;
    end
endmodule

// File: rtl/sigdet_status_router.sv
module sigdet_status_router
    import sigdet_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int CNT_W = 8,
    parameter int PER_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode,
    input  logic [PER_W-1:0]        period_len,
    input  logic signed [SMP_W-1:0] samp_a,
    input  logic signed [SMP_W-1:0] samp_b,
    input  logic [SMP_W-1:0]        a_hi_thr,
    input  logic [SMP_W-1:0]        a_lo_thr,
    input  logic [CNT_W-1:0]        a_hi_lim,
    input  logic [CNT_W-1:0]        a_lo_lim,
    input  logic [SMP_W-1:0]        b_hi_thr,
    input  logic [SMP_W-1:0]        b_lo_thr,
    input  logic [CNT_W-1:0]        b_hi_lim,
    input  logic [CNT_W-1:0]        b_lo_lim,
    input  logic [2*SMP_W-1:0]      pwr_lo_thr,
    input  logic [2*SMP_W-1:0]      pwr_hi_thr,
    input  logic [PAIR_SEL_W-1:0]   sel_pair0,
    input  logic [PAIR_SEL_W-1:0]   sel_pair1,
    output logic [3:0]              status,
    output logic [PIN_W-1:0]        pins
);
    localparam int NPATH = 2;

    logic [PER_W-1:0]             period_pos;
    logic                         period_last;
    det_flags_t                   flags;
    logic [NPATH-1:0][SMP_W-1:0]  p_samp;
    logic [NPATH-1:0][SMP_W-1:0]  p_thr_hi;
    logic [NPATH-1:0][SMP_W-1:0]  p_thr_lo;
    logic [NPATH-1:0][CNT_W-1:0]  p_lim_hi;
    logic [NPATH-1:0][CNT_W-1:0]  p_lim_lo;
    logic [NPATH-1:0]             p_hi;
    logic [NPATH-1:0]             p_lo;
    logic                         pw_lo;
    logic                         pw_hi;

    assign p_samp   = {samp_b, samp_a};
    assign p_thr_hi = {b_hi_thr, a_hi_thr};
    assign p_thr_lo = {b_lo_thr, a_lo_thr};
    assign p_lim_hi = {b_hi_lim, a_hi_lim};
    assign p_lim_lo = {b_lo_lim, a_lo_lim};

    sigdet_period_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_len (period_len),
        .pos        (period_pos),
        .last       (period_last)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        sigdet_peak_counter #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_peak (
            .clk     (clk),
            .rst     (rst),
            .samp    (p_samp[p]),
            .thr_hi  (p_thr_hi[p]),
            .thr_lo  (p_thr_lo[p]),
            .lim_hi  (p_lim_hi[p]),
            .lim_lo  (p_lim_lo[p]),
            .last    (period_last),
            .flag_hi (p_hi[p]),
            .flag_lo (p_lo[p])
        );
    end

    sigdet_power_meter #(.SMP_W(SMP_W), .PER_W(PER_W)) u_power (
        .clk     (clk),
        .rst     (rst),
        .samp    (samp_a),
        .thr_lo  (pwr_lo_thr),
        .thr_hi  (pwr_hi_thr),
        .pos     (period_pos),
        .last    (period_last),
        .flag_lo (pw_lo),
        .flag_hi (pw_hi)
    );

    always_comb begin
        flags.a_lo   = p_lo[0];
        flags.a_hi   = p_hi[0];
        flags.b_lo   = p_lo[1];
        flags.b_hi   = p_hi[1];
        flags.pwr_lo = pw_lo;
        flags.pwr_hi = pw_hi;
        status       = pick_status(det_mode_e'(mode), flags);
    end

    sigdet_pin_router #(.PAIRS(PIN_PAIRS), .SEL_W(PAIR_SEL_W)) u_router (
        .status (status),
        .sel0   (sel_pair0),
        .sel1   (sel_pair1),
        .pins   (pins)
    );
endmodule

// File: rtl/sigdet_status_router_chk.sv
module sigdet_status_router_chk
    import sigdet_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  mode,
    input logic                  period_last,
    input logic [PAIR_SEL_W-1:0] sel_pair0,
    input logic [PAIR_SEL_W-1:0] sel_pair1,
    input logic [3:0]            status,
    input logic [PIN_W-1:0]      pins
);
    logic [1:0] at_sel0;
    logic [1:0] at_sel1;
    logic       live0;
    logic       live1;

    assign live0 = pair_code_live(sel_pair0);
    assign live1 = pair_code_live(sel_pair1);

    always_comb begin
        at_sel0 = 2'b00;
        at_sel1 = 2'b00;
        for (int k = 0; k < PIN_PAIRS; k++) begin
            if (sel_pair0 == PAIR_SEL_W'(k + 1)) at_sel0 = pins[2*k +: 2];
            if (sel_pair1 == PAIR_SEL_W'(k + 1)) at_sel1 = pins[2*k +: 2];
        end
    end

    // R2
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(period_last) && $stable(mode)) |-> $stable(status));

    // R10
    unassigned_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!live0 && !live1) |-> (pins == '0));

    // R9
    pair0_route_chk: assert property (@(posedge clk) disable iff (rst)
        live0 |-> (at_sel0 == status[1:0]));

    // R9
    pair1_route_chk: assert property (@(posedge clk) disable iff (rst)
        (live1 && (sel_pair1 != sel_pair0)) |-> (at_sel1 == status[3:2]));

    // R11
    collide_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (live0 && (sel_pair0 == sel_pair1)) |-> ($countones(pins) == $countones(status[1:0])));
endmodule

bind sigdet_status_router sigdet_status_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .period_last (period_last),
    .sel_pair0   (sel_pair0),
    .sel_pair1   (sel_pair1),
    .status      (status),
    .pins        (pins)
);

// File: tb/sigdet_status_router_bench.sv
module sigdet_status_router_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               mode = 1'b0;
    logic [15:0]        period_len = 16'd8;
    logic signed [11:0] samp_a = '0;
    logic signed [11:0] samp_b = '0;
    logic [11:0]        a_hi_thr = '0, a_lo_thr = '0, b_hi_thr = '0, b_lo_thr = '0;
    logic [7:0]         a_hi_lim = '0, a_lo_lim = '0, b_hi_lim = '0, b_lo_lim = '0;
    logic [23:0]        pwr_lo_thr = '0, pwr_hi_thr = '0;
    logic [3:0]         sel_pair0 = '0, sel_pair1 = '0;
    logic [3:0]         status;
    logic [15:0]        pins;

    int checks = 0;
    int errors = 0;
    int sa [0:511];
    int sb [0:511];
    // expected flags: [0]a_lo [1]b_lo [2]a_hi [3]b_hi [4]pwr_lo [5]pwr_hi
    logic [5:0] ef = '0;

    always #5 clk = ~clk;

    sigdet_status_router u_sigdet_status_router (
        .clk(clk), .rst(rst), .mode(mode), .period_len(period_len),
        .samp_a(samp_a), .samp_b(samp_b),
        .a_hi_thr(a_hi_thr), .a_lo_thr(a_lo_thr), .a_hi_lim(a_hi_lim), .a_lo_lim(a_lo_lim),
        .b_hi_thr(b_hi_thr), .b_lo_thr(b_lo_thr), .b_hi_lim(b_hi_lim), .b_lo_lim(b_lo_lim),
        .pwr_lo_thr(pwr_lo_thr), .pwr_hi_thr(pwr_hi_thr),
        .sel_pair0(sel_pair0), .sel_pair1(sel_pair1),
        .status(status), .pins(pins)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_status(logic m, logic [5:0] f);
        if (!m) return f[3:0];
        return {f[3], f[1], f[5], f[4]};
    endfunction

    function automatic logic [15:0] exp_pins(logic [3:0] st, int s0, int s1);
        logic [15:0] p = '0;
        for (int k = 1; k <= 8; k++) begin
            if (s0 == k)      p[2*k-2 +: 2] = st[1:0];
            else if (s1 == k) p[2*k-2 +: 2] = st[3:2];
        end
        return p;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_outputs(input string tag);
        logic [3:0] st = exp_status(mode, ef);
        check({tag, " status"}, 32'(status), 32'(st));
        check({tag, " pins"}, 32'(pins), 32'(exp_pins(st, int'(sel_pair0), int'(sel_pair1))));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        samp_a = '0;
        samp_b = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset status", 32'(status), 32'h0);
        check("R1 reset pins", 32'(pins), 32'h0);
        rst = 1'b0;
        ef = '0;
    endtask

    // Drives one full period from sa/sb and predicts the flags (R2..R6).
    task automatic run_period(input int n);
        int ca_hi = 0, ca_lo = 0, cb_hi = 0, cb_lo = 0;
        longint psum = 0;
        for (int i = 0; i < n; i++) begin
            // R2: flags of the previous period hold on every clock
            check("R2 hold", 32'(status), 32'(exp_status(mode, ef)));
            samp_a = 12'(sa[i]);
            samp_b = 12'(sb[i]);
            if (iabs(sa[i]) > int'(a_hi_thr)) ca_hi++;
            if (iabs(sa[i]) > int'(a_lo_thr)) ca_lo++;
            if (iabs(sb[i]) > int'(b_hi_thr)) cb_hi++;
            if (iabs(sb[i]) > int'(b_lo_thr)) cb_lo++;
            psum += longint'(sa[i]) * longint'(sa[i]);
            @(posedge clk);
            @(negedge clk);
        end
        // R5: saturating counts
        if (ca_hi > 255) ca_hi = 255;
        if (ca_lo > 255) ca_lo = 255;
        if (cb_hi > 255) cb_hi = 255;
        if (cb_lo > 255) cb_lo = 255;
        ef[0] = (ca_lo >= int'(a_lo_lim));
        ef[1] = (cb_lo >= int'(b_lo_lim));
        ef[2] = (ca_hi >= int'(a_hi_lim));
        ef[3] = (cb_hi >= int'(b_hi_lim));
        ef[4] = (psum > longint'(pwr_lo_thr) * n);
        ef[5] = (psum > longint'(pwr_hi_thr) * n);
    endtask

    task automatic t_strict();
        int va [8] = '{100, 101, -101, -100, 5, 21, -21, 20};
        mode = 1'b0; period_len = 16'd8;
        a_hi_thr = 12'd100; a_lo_thr = 12'd20; a_hi_lim = 8'd2; a_lo_lim = 8'd6;
        b_hi_thr = 12'd2047; b_lo_thr = 12'd0; b_hi_lim = 8'd1; b_lo_lim = 8'd2;
        sel_pair0 = 4'd1; sel_pair1 = 4'd8;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            sa[i] = va[i];
            sb[i] = (i == 0) ? -2048 : 0;
        end
        run_period(8);
        // R3 R4 R7: hand-worked word {b_hi,a_hi,b_lo,a_lo}
        check("R3 R4 R7 peak word", 32'(status), 32'hD);
        // R9: pair0 -> pins 1:0, pair1 -> pins 15:14
        check("R9 routed pins", 32'(pins), 32'hC001);
        check_outputs("R4 model");
        // R4: one more hit needed now, same data
        a_hi_lim = 8'd3;
        a_lo_lim = 8'd7;
        run_period(8);
        check("R4 limit above count", 32'(status), 32'h8);
        check_outputs("R4 second period");
    endtask

    task automatic t_routing();
        // status held from the first strict period: 4'hD
        a_hi_lim = 8'd2; a_lo_lim = 8'd6;
        run_period(8);
        check("R7 restore", 32'(status), 32'hD);
        for (int s = 0; s < 16; s++) begin
            sel_pair0 = 4'(s); sel_pair1 = 4'd0;
            #1;
            check("R9 R10 R12 sel0 sweep", 32'(pins), 32'(exp_pins(4'hD, s, 0)));
            sel_pair0 = 4'd0; sel_pair1 = 4'(s);
            #1;
            check("R9 R10 R12 sel1 sweep", 32'(pins), 32'(exp_pins(4'hD, 0, s)));
        end
        sel_pair0 = 4'd3; sel_pair1 = 4'd3;
        #1;
        // R11: pair 0 (2'b01) wins on pins 5:4
        check("R11 collision", 32'(pins), 32'h0010);
        sel_pair0 = 4'd9; sel_pair1 = 4'd12;
        #1;
        check("R10 out-of-range codes", 32'(pins), 32'h0);
        sel_pair0 = 4'd2; sel_pair1 = 4'd5;
        @(negedge clk);
    endtask

    task automatic t_power();
        mode = 1'b1; period_len = 16'd8;
        pwr_lo_thr = 24'd99; pwr_hi_thr = 24'd100;
        b_hi_thr = 12'd50; b_lo_thr = 12'd49; b_hi_lim = 8'd1; b_lo_lim = 8'd8;
        sel_pair0 = 4'd2; sel_pair1 = 4'd4;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            sa[i] = (i % 2 == 0) ? 10 : -10;
            sb[i] = (i % 2 == 0) ? 50 : -50;
        end
        run_period(8);
        // R6 R8: sum 800 vs 792 and 800 (strict)
        check("R6 R8 power word", 32'(status), 32'h5);
        check_outputs("R6 model");
        pwr_hi_thr = 24'd99;
        run_period(8);
        check("R6 inner high set", 32'(status), 32'h7);
        // R12: mode change reorders at once from held flags
        mode = 1'b0;
        #1;
        check("R12 mode switch", 32'(status), 32'(exp_status(1'b0, ef)));
        mode = 1'b1;
        #1;
        check("R12 mode back", 32'(status), 32'h7);
        @(negedge clk);
    endtask

    task automatic t_saturate();
        mode = 1'b0; period_len = 16'd300;
        a_hi_thr = 12'd0; a_lo_thr = 12'd0; a_hi_lim = 8'd255; a_lo_lim = 8'd255;
        b_hi_thr = 12'd0; b_lo_thr = 12'd0; b_hi_lim = 8'd255; b_lo_lim = 8'd0;
        sel_pair0 = 4'd1; sel_pair1 = 4'd2;
        do_reset();
        for (int i = 0; i < 300; i++) begin
            sa[i] = 1000;
            sb[i] = 0;
        end
        run_period(300);
        // R5: 300 hits stop at 255; a wrap would leave 44
        check("R5 saturation", 32'(status), 32'h7);
        check_outputs("R5 model");
    endtask

    task automatic t_short_period();
        mode = 1'b0; period_len = 16'd1;
        a_hi_thr = 12'd500; a_lo_thr = 12'd10; a_hi_lim = 8'd1; a_lo_lim = 8'd1;
        b_hi_thr = 12'd500; b_lo_thr = 12'd10; b_hi_lim = 8'd1; b_lo_lim = 8'd1;
        sel_pair0 = 4'd1; sel_pair1 = 4'd2;
        do_reset();
        for (int r = 0; r < 6; r++) begin
            sa[0] = (r % 3 == 0) ? -600 : ((r % 3 == 1) ? 11 : 10);
            sb[0] = (r % 2 == 0) ? 0 : 501;
            run_period(1);
            // R2: one-sample periods update every clock
            check_outputs("R2 single-sample period");
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_strict();
        t_routing();
        t_power();
        t_saturate();
        t_short_period();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule